// File: doc/BRIEF.md
# Parallel ADC Conversion Read Controller

This block sits on the host side of a 16-bit sampling converter with a parallel output bus. It launches each conversion with an active-low start strobe. It then follows the converter's busy line as it falls and rises again, and reads the result back with a chip-select and read pulse pair. Every minimum width, setup, hold and release time is given in nanoseconds as a parameter. Each one is turned into a whole number of system-clock cycles, rounded up.

There are two bus widths. In word mode a single read captures all 16 bits. In byte mode the data comes over the low eight bus lines in two reads: the low half first, with the half-select line low, and then the high half with it high. A conversion can be requested with a one-cycle pulse or by a free-running sample timer. A request that arrives while a conversion or read is already in progress is remembered and served afterwards. The result is sign-extended to the output width and presented with a one-cycle valid strobe. A timeout guard watches each busy edge and raises a one-cycle error pulse if that edge does not come.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and in the cycles after it, the start strobe, chip select and read are high, the half-select is low, and the valid strobe and error pulse are low.
- R2: Each accepted request drives the start strobe low for exactly ceil(50 ns / clock period) cycles. This is 7 cycles at 125 MHz.
- R3: In word mode (byte_mode = 0 when the strobe begins), after busy has fallen and risen, exactly one read pulse is issued. The result is the full 16-bit bus value sampled on the last cycle of that pulse.
- R4: Chip select is low in every cycle in which read is low. Each read pulse lasts ceil(max(60 ns, 57 ns) / clock period) cycles, which is 8 cycles at 125 MHz.
- R5: In byte mode (byte_mode = 1 when the strobe begins), two read pulses take bus_d[7:0]. The first is issued with hben = 0 and supplies result bits 7:0. The second is issued with hben = 1 and supplies bits 15:8. hben does not change while read is low.
- R6: No start strobe is issued while a conversion or read is in progress. Any number of requests made during that time cause exactly one further conversion once the read has finished.
- R7: res_valid is high for exactly one cycle per completed conversion. In byte mode this cycle comes after the second byte.
- R8: res_data is the 16-bit two's-complement code sign-extended to OUT_W bits, so bits OUT_W-1 down to 15 all equal code bit 15.
- R9: If busy is not seen low within ceil(TO_FALL_NS / clock period) cycles after the strobe ends, err_timeout pulses for one cycle. The controller then returns to idle without a read or a valid strobe and still accepts later requests.
- R10: If busy is not seen high within ceil(TO_RISE_NS / clock period) cycles after it fell, err_timeout pulses for one cycle and no read is made.
- R11: With free_run = 1 and each conversion shorter than the period, start strobes begin every ceil(SAMPLE_NS / clock period) cycles. This is 753 cycles at 125 MHz for 6024 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle conversion request |
| free_run | input | 1 | Enables the periodic sample timer |
| byte_mode | input | 1 | 1 selects two 8-bit reads, 0 one 16-bit read; latched at the strobe |
| busy | input | 1 | Converter busy, low during conversion (asynchronous) |
| bus_d | input | 16 | Converter data bus; only bits 7:0 are used in byte mode |
| conv_n | output | 1 | Active-low conversion start strobe |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read |
| hben | output | 1 | Half select: 0 low byte, 1 high byte |
| res_data | output | OUT_W | Sign-extended result |
| res_valid | output | 1 | One-cycle result strobe |
| err_timeout | output | 1 | One-cycle busy timeout pulse |

## Verification
The request-pending logic can take a new request in the same cycle as it hands an earlier one to the sequencer, or while the sequencer is reading. The bench provokes this by pulsing start_req while the converter model holds busy low, and again back to back. It judges the result by counting start strobes and results: there must be exactly one extra conversion, and the scoreboard queue must be empty at the end. A second overlap is between a byte-mode half-select change and the end of a read pulse. This is judged by watching hben across every read-low cycle, and by checking that the assembled words match the queue.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CONV, S_WFALL, S_WRISE, S_SETUP, S_READ, S_HOLD, S_GAP
  } seq_st_t;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_pace.sv
module adc_rd_pace #(
  parameter int unsigned SAMPLE_CYC = 753
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic free_run,
  input  logic accept,
  output logic pending,
  output logic tick
);
  localparam int unsigned CW = $clog2(SAMPLE_CYC + 1);

  logic [CW-1:0] cnt;

  assign tick = free_run && (cnt == CW'(SAMPLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (!free_run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
      // a request landing in the accept cycle survives
      pending <= (pending && !accept) || start_req || tick;
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned CONV_CYC    = 7,
  parameter int unsigned TO_FALL_CYC = 25,
  parameter int unsigned TO_RISE_CYC = 750,
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned RD_CYC      = 8,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned GAP_CYC     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic byte_mode,
  input  logic busy,
  output logic accept,
  output logic conv_n,
  output logic cs_n,
  output logic rd_n,
  output logic hben,
  output logic cap_lo,
  output logic cap_hi,
  output logic cap_word,
  output logic ev_timeout
);
  localparam int unsigned TMAX = umax(umax(TO_RISE_CYC, TO_FALL_CYC),
                                      umax(umax(CONV_CYC, RD_CYC), umax(GAP_CYC, umax(SETUP_CYC, HOLD_CYC))));
  localparam int unsigned TW = $clog2(TMAX + 1);

  seq_st_t       st;
  logic [TW-1:0] tmr;
  logic          hi_ph, mode_q, bsy_m, bsy_s, tmr_end, rd_last;

  assign tmr_end    = (tmr == '0);
  assign accept     = (st == S_IDLE) && pending;
  assign rd_last    = (st == S_READ) && tmr_end;
  assign cap_word   = rd_last && !mode_q;
  assign cap_lo     = rd_last && mode_q && !hi_ph;
  assign cap_hi     = rd_last && mode_q && hi_ph;
  assign ev_timeout = tmr_end && (((st == S_WFALL) && bsy_s) || ((st == S_WRISE) && !bsy_s));
  assign conv_n     = (st != S_CONV);
  assign cs_n       = !((st == S_SETUP) || (st == S_READ) || (st == S_HOLD));
  assign rd_n       = (st != S_READ);
  assign hben       = hi_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      hi_ph  <= 1'b0;
      mode_q <= 1'b0;
      bsy_m  <= 1'b1;
      bsy_s  <= 1'b1;
    end else begin
      bsy_m <= busy;
      bsy_s <= bsy_m;
      if (!tmr_end) tmr <= tmr - 1'b1;
      unique case (st)
        S_IDLE: if (pending) begin
          st     <= S_CONV;
          tmr    <= TW'(CONV_CYC - 1);
          mode_q <= byte_mode;
          hi_ph  <= 1'b0;
        end
        S_CONV: if (tmr_end) begin
          st  <= S_WFALL;
          tmr <= TW'(TO_FALL_CYC - 1);
        end
        S_WFALL: if (!bsy_s) begin
          st  <= S_WRISE;
          tmr <= TW'(TO_RISE_CYC - 1);
        end else if (tmr_end) st <= S_IDLE;
        S_WRISE: if (bsy_s) begin
          st  <= S_SETUP;
          tmr <= TW'(SETUP_CYC - 1);
        end else if (tmr_end) st <= S_IDLE;
        S_SETUP: if (tmr_end) begin
          st  <= S_READ;
          tmr <= TW'(RD_CYC - 1);
        end
        S_READ: if (tmr_end) begin
          st  <= S_HOLD;
          tmr <= TW'(HOLD_CYC - 1);
        end
        S_HOLD: if (tmr_end) begin
          st  <= S_GAP;
          tmr <= TW'(GAP_CYC - 1);
        end
        S_GAP: if (tmr_end) begin
          if (mode_q && !hi_ph) begin
            hi_ph <= 1'b1;
            st    <= S_SETUP;
            tmr   <= TW'(SETUP_CYC - 1);
          end else begin
            hi_ph <= 1'b0;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_asm.sv
module adc_rd_asm #(
  parameter int unsigned OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_d,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic             cap_word,
  output logic [OUT_W-1:0] res_data,
  output logic             res_valid
);
  logic [7:0] lo_q;

  function automatic logic [OUT_W-1:0] widen(input logic [15:0] code);
    return {{(OUT_W-16){code[15]}}, code};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= cap_hi || cap_word;
      if (cap_lo)   lo_q     <= bus_d[7:0];
      if (cap_hi)   res_data <= widen({bus_d[7:0], lo_q});
      if (cap_word) res_data <= widen(bus_d);
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_PS     = 8000,
  parameter int unsigned CONV_NS    = 50,
  parameter int unsigned RD_NS      = 60,
  parameter int unsigned ACC_NS     = 57,
  parameter int unsigned REL_NS     = 50,
  parameter int unsigned HB_SU_NS   = 10,
  parameter int unsigned HB_HD_NS   = 25,
  parameter int unsigned HB_LVL_NS  = 60,
  parameter int unsigned TO_FALL_NS = 200,
  parameter int unsigned TO_RISE_NS = 6000,
  parameter int unsigned SAMPLE_NS  = 6024,
  parameter int unsigned OUT_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             free_run,
  input  logic             byte_mode,
  input  logic             busy,
  input  logic [15:0]      bus_d,
  output logic             conv_n,
  output logic             cs_n,
  output logic             rd_n,
  output logic             hben,
  output logic [OUT_W-1:0] res_data,
  output logic             res_valid,
  output logic             err_timeout
);
  localparam int unsigned CONV_CYC    = ns_to_cyc(CONV_NS, CLK_PS);
  localparam int unsigned RD_CYC      = umax(ns_to_cyc(RD_NS, CLK_PS), ns_to_cyc(ACC_NS, CLK_PS));
  localparam int unsigned SETUP_CYC   = ns_to_cyc(HB_SU_NS, CLK_PS);
  localparam int unsigned HOLD_CYC    = ns_to_cyc(HB_HD_NS, CLK_PS);
  localparam int unsigned GAP_CYC     = umax(ns_to_cyc(REL_NS, CLK_PS), ns_to_cyc(HB_LVL_NS, CLK_PS));
  localparam int unsigned TO_FALL_CYC = ns_to_cyc(TO_FALL_NS, CLK_PS);
  localparam int unsigned TO_RISE_CYC = ns_to_cyc(TO_RISE_NS, CLK_PS);
  localparam int unsigned SAMPLE_CYC  = ns_to_cyc(SAMPLE_NS, CLK_PS);

  // named internal events
  logic pending, accept, tick, cap_lo, cap_hi, cap_word, ev_timeout;

  assign err_timeout = ev_timeout;

  adc_rd_pace #(.SAMPLE_CYC(SAMPLE_CYC)) u_pace (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .accept(accept), .pending(pending), .tick(tick)
  );

  adc_rd_seq #(
    .CONV_CYC(CONV_CYC), .TO_FALL_CYC(TO_FALL_CYC), .TO_RISE_CYC(TO_RISE_CYC),
    .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .byte_mode(byte_mode), .busy(busy),
    .accept(accept), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .cap_word(cap_word), .ev_timeout(ev_timeout)
  );

  adc_rd_asm #(.OUT_W(OUT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .cap_word(cap_word), .res_data(res_data), .res_valid(res_valid)
  );
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int unsigned CONV_CYC = 7,
  parameter int unsigned RD_CYC   = 8,
  parameter int unsigned OUT_W    = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             hben,
  input logic [OUT_W-1:0] res_data,
  input logic             res_valid,
  input logic             ev_timeout
);
  logic [15:0] conv_lo_cnt, rd_lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_lo_cnt <= '0;
      rd_lo_cnt   <= '0;
    end else begin
      if (conv_n) conv_lo_cnt <= '0;
      else if (conv_lo_cnt != 16'hFFFF) conv_lo_cnt <= conv_lo_cnt + 1'b1;
      if (rd_n) rd_lo_cnt <= '0;
      else if (rd_lo_cnt != 16'hFFFF) rd_lo_cnt <= rd_lo_cnt + 1'b1;
    end
  end

  AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> (conv_lo_cnt >= 16'(CONV_CYC))); // R2
  AST_CS_COVERS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n); // R4
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_lo_cnt >= 16'(RD_CYC))); // R4
  AST_HBEN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> $stable(hben)); // R5
  AST_NO_CONV_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_n |-> (cs_n && rd_n)); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (($countones(res_data[OUT_W-1:15]) == 0) ||
                   ($countones(res_data[OUT_W-1:15]) == OUT_W - 15))); // R8
  AST_TIMEOUT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> (cs_n && conv_n)); // R9
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.CONV_CYC(CONV_CYC), .RD_CYC(RD_CYC), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
  .res_data(res_data), .res_valid(res_valid), .ev_timeout(ev_timeout)
);

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;
  localparam int OUT_W      = 24;
  localparam int CONV_CYC   = 7;    // ceil(50/8)
  localparam int RD_CYC     = 8;    // ceil(60/8)
  localparam int SAMPLE_CYC = 753;  // ceil(6024/8)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, free_run = 1'b0, byte_mode = 1'b0;
  logic busy;
  logic [15:0] bus_d;
  logic conv_n, cs_n, rd_n, hben, res_valid, err_timeout;
  logic [OUT_W-1:0] res_data;

  always #4 clk = ~clk;

  adc_rd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .byte_mode(byte_mode), .busy(busy), .bus_d(bus_d), .conv_n(conv_n),
    .cs_n(cs_n), .rd_n(rd_n), .hben(hben), .res_data(res_data),
    .res_valid(res_valid), .err_timeout(err_timeout)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_conv = 0, n_res = 0, n_err = 0;
  bit sup_fall = 0, sup_rise = 0, abort_rise = 0;
  logic [15:0] code_q[$];
  logic [OUT_W-1:0] sb_q[$];
  bit hb_log[$];
  int conv_t[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  logic [15:0] cur = 16'h0;
  int ph = 0, dly = 0;
  logic conv_prev = 1'b1;
  assign bus_d = (!cs_n && !rd_n) ? (byte_mode ? {8'h00, hben ? cur[15:8] : cur[7:0]} : cur) : 16'hA5A5;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 1'b1; ph = 0;
    end else begin
      case (ph)
        0: if (conv_prev && !conv_n && !sup_fall) begin ph = 1; dly = 3; end
        1: begin dly--; if (dly == 0) begin busy = 1'b0; ph = 2; dly = 40; end end
        default: begin
          if (abort_rise) begin busy = 1'b1; ph = 0; end
          else if (!sup_rise) begin
            dly--;
            if (dly == 0) begin
              logic signed [OUT_W-1:0] e;
              cur = (code_q.size() > 0) ? code_q.pop_front() : 16'h0000;
              e = $signed(cur);
              sb_q.push_back(e);
              busy = 1'b1; ph = 0;
            end
          end
        end
      endcase
    end
    conv_prev = conv_n;
  end

  // monitor: scoreboard pop, pulse widths, hben stability
  int conv_lo = 0, rd_lo = 0;
  logic hb_prev = 1'b0, rd_prev = 1'b1, val_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!conv_n) begin
        if (conv_lo == 0) begin n_conv++; conv_t.push_back(cyc); end
        conv_lo++;
        chk(cs_n && rd_n, "R6 strobe during read", {cs_n, rd_n}, 2'b11);
      end else if (conv_lo != 0) begin
        chk(conv_lo == CONV_CYC, "R2 strobe width", conv_lo, CONV_CYC);
        conv_lo = 0;
      end
      if (!rd_n) begin
        if (rd_prev) hb_log.push_back(hben);
        else if (hben != hb_prev) chk(0, "R5 hben moved in read", hben, hb_prev);
        rd_lo++;
      end else if (rd_lo != 0) begin
        chk(rd_lo == RD_CYC, "R4 read width", rd_lo, RD_CYC);
        rd_lo = 0;
      end
      if (res_valid) begin
        n_res++;
        chk(!val_prev, "R7 valid wider than one cycle", 1, 0);
        if (sb_q.size() == 0) chk(0, "R7 result without conversion", res_data, 0);
        else begin
          logic [OUT_W-1:0] ex;
          ex = sb_q.pop_front();
          chk(res_data == ex, "R3/R5/R8 result value", res_data, ex);
        end
      end
      if (err_timeout) n_err++;
      hb_prev = hben; rd_prev = rd_n; val_prev = res_valid;
    end
  end

  task automatic pulse_req();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic convert(input logic [15:0] c, input bit bm);
    byte_mode = bm;
    code_q.push_back(c);
    pulse_req();
    repeat (150) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int c0, r0, e0;
    repeat (5) @(negedge clk);
    chk({conv_n, cs_n, rd_n, hben, res_valid, err_timeout} == 6'b111000, "R1 reset outputs",
        {conv_n, cs_n, rd_n, hben, res_valid, err_timeout}, 6'b111000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({conv_n, cs_n, rd_n, hben, res_valid} == 5'b11100, "R1 idle after reset",
        {conv_n, cs_n, rd_n, hben, res_valid}, 5'b11100);

    // R3 R8 word mode, several codes
    convert(16'h1234, 0); convert(16'h8000, 0); convert(16'h7FFF, 0); convert(16'hFFFF, 0);
    chk(n_res == 4, "R3 word results", n_res, 4);

    // R5 byte mode
    hb_log.delete();
    convert(16'h8001, 1);
    chk(hb_log.size() == 2 && hb_log[0] == 0 && hb_log[1] == 1, "R5 low then high byte",
        hb_log.size(), 2);
    convert(16'h00FF, 1); convert(16'hABCD, 1);
    chk(n_res == 7, "R5 byte results", n_res, 7);

    // R6 requests during conversion are held and merged
    c0 = n_conv; r0 = n_res;
    byte_mode = 0;
    code_q.push_back(16'h4321); code_q.push_back(16'hC0DE);
    pulse_req();
    wait (busy == 1'b0);
    pulse_req(); pulse_req();
    repeat (400) @(negedge clk);
    chk(n_conv - c0 == 2, "R6 conversions after merged requests", n_conv - c0, 2);
    chk(n_res - r0 == 2, "R6 results after merged requests", n_res - r0, 2);

    // R9 busy never falls
    c0 = n_conv; r0 = n_res; e0 = n_err;
    sup_fall = 1; pulse_req(); repeat (80) @(negedge clk); sup_fall = 0;
    chk(n_err - e0 == 1, "R9 fall timeout pulse", n_err - e0, 1);
    chk(n_res == r0, "R9 no result on fall timeout", n_res - r0, 0);
    convert(16'h5A5A, 0);
    chk(n_res - r0 == 1, "R9 recovery conversion", n_res - r0, 1);

    // R10 busy never rises
    r0 = n_res; e0 = n_err;
    sup_rise = 1; pulse_req(); repeat (900) @(negedge clk);
    chk(n_err - e0 == 1, "R10 rise timeout pulse", n_err - e0, 1);
    chk(n_res == r0, "R10 no result on rise timeout", n_res - r0, 0);
    abort_rise = 1; @(negedge clk); @(negedge clk); abort_rise = 0; sup_rise = 0;
    repeat (10) @(negedge clk);

    // R11 free-running timer
    conv_t.delete();
    byte_mode = 1;
    free_run = 1;
    repeat (SAMPLE_CYC * 3 + 20) @(negedge clk);
    free_run = 0;
    repeat (SAMPLE_CYC + 200) @(negedge clk);
    chk(conv_t.size() >= 3, "R11 strobes seen", conv_t.size(), 3);
    if (conv_t.size() >= 3)
      chk(conv_t[2] - conv_t[1] == SAMPLE_CYC, "R11 strobe period", conv_t[2] - conv_t[1], SAMPLE_CYC);

    chk(sb_q.size() == 0, "R7 every conversion produced one result", sb_q.size(), 0);
    finish_run();
  end
endmodule